// File: doc/BRIEF.md
# Phase-Frequency Comparator with Hysteretic Lock Flag

This block compares two divided pulse trains, the reference tick and the VCO feedback tick, both one oscillator-clock wide and synchronous to the oscillator clock. It produces the pump-up and pump-down requests for an external charge pump. When one tick arrives, its side of the comparator latches. When the other tick arrives, both sides clear together one cycle later. The comparator therefore behaves as a phase detector over plus or minus one period and as a frequency detector beyond that. Even at zero phase error, both requests pulse for one clock each period, which prevents a dead zone.

The phase error is the number of oscillator clocks during which exactly one side is latched. The lock flag uses two thresholds. It drops as soon as the running error reaches the wide unlock threshold. It rises only after three consecutive comparisons, each with an error no larger than the narrow lock threshold. A polarity input exchanges the up and down roles to match the VCO tuning slope. A pump-enable input silences both requests and signals high impedance to the pump. A select input routes either the lock flag or the feedback tick to a shared output pin. The current-range bit for the pump passes straight through.

Top module: `pfd_lock_top`

## Requirements
- R1: While reset is asserted, and after it is released, pump_up_o, pump_dn_o and lock_o are 0 until the first ticks arrive.
- R2: A tick latches its side. The latched side stays high until both sides are latched, and both then clear on the next clock. A side that leads by d clocks is therefore high for d+1 cycles, and the lagging side for exactly 1 cycle. Coincident ticks give one-cycle pulses on both sides.
- R3: With polarity_i=1, pump_up_o follows the reference side and pump_dn_o follows the VCO side. With polarity_i=0, the two are exchanged.
- R4: The phase error of a comparison is the number of clocks during which exactly one side was latched. For ticks d clocks apart, the error equals |d|.
- R5: lock_o goes to 0 on the clock after the running error reaches thr_unlock_i, even before the comparison completes. The consecutive-good count is cleared at the same time.
- R6: lock_o goes to 1 only after 3 consecutive comparisons each with error <= thr_lock_i. A comparison with an error above thr_lock_i and below thr_unlock_i restarts the count and leaves lock_o unchanged.
- R7: With pump_en_i=0, pump_up_o, pump_dn_o and pump_oe_o are all 0, while the lock logic keeps running. With pump_en_i=1, pump_oe_o is 1.
- R8: With out_sel_i=1, shared_o carries vco_tick_i. With out_sel_i=0, shared_o carries lock_o.
- R9: cur_hi_o always equals cur_hi_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_tick_i | input | 1 | Divided reference pulse, one clock wide |
| vco_tick_i | input | 1 | Divided VCO pulse, one clock wide |
| polarity_i | input | 1 | 1: reference leading drives up; 0: roles exchanged |
| pump_en_i | input | 1 | 0 forces pump outputs quiet and high impedance |
| cur_hi_i | input | 1 | Pump current range select |
| out_sel_i | input | 1 | 1: shared pin shows VCO tick; 0: lock flag |
| thr_unlock_i | input | ERR_W | Unlock threshold in clocks |
| thr_lock_i | input | ERR_W | Lock threshold in clocks, below thr_unlock_i |
| pump_up_o | output | 1 | Pump-up request |
| pump_dn_o | output | 1 | Pump-down request |
| pump_oe_o | output | 1 | Pump output drive enable |
| cur_hi_o | output | 1 | Current range select to pump |
| lock_o | output | 1 | Lock indicator |
| shared_o | output | 1 | Lock flag or VCO tick, per out_sel_i |

## Verification
The comparator is driven with a sweep of fixed offsets between the two ticks. These are zero offset, reference leading by one, two and four clocks, and VCO leading by one and three. The pulse widths separate the leading side from the lagging side, and the zero-offset case shows the anti-dead-zone pulses. Runs of small offsets confirm that lock needs exactly three good comparisons. A mid-band offset between the two thresholds shows the restart of the count, and shows that an existing lock is kept. Offsets at or above the unlock threshold show the immediate drop. The same offsets are repeated with the polarity flipped and with the pump disabled, so that the up/down exchange and the silenced outputs can be told apart from the comparator's own behaviour.

// File: rtl/pfdl_pkg.sv
package pfdl_pkg;
  // Number of consecutive good comparisons needed before lock is declared.
  localparam int unsigned LOCK_RUN_DEF = 3;

  typedef struct packed {
    logic up;
    logic dn;
  } pump_req_t;
endpackage

// File: rtl/pfd_core.sv
module pfd_core (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_tick_i,
  input  logic vco_tick_i,
  output logic ref_lat_o,
  output logic vco_lat_o,
  output logic cmp_o
);
  logic ref_q, vco_q, ref_d, vco_d, both;

  assign both = ref_q & vco_q;

  always_comb begin
    ref_d = ref_q;
    vco_d = vco_q;
    if (both) begin
      ref_d = 1'b0;
      vco_d = 1'b0;
    end else begin
      ref_d = ref_q | ref_tick_i;
      vco_d = vco_q | vco_tick_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q <= 1'b0;
      vco_q <= 1'b0;
    end else begin
      ref_q <= ref_d;
      vco_q <= vco_d;
    end
  end

  assign ref_lat_o = ref_q;
  assign vco_lat_o = vco_q;
  assign cmp_o     = both;

  AST_BOTH_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_q && vco_q) |=> (!ref_q && !vco_q)); // R2
endmodule

// File: rtl/phase_meter.sv
module phase_meter #(
  parameter int unsigned ERR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_lat_i,
  input  logic             vco_lat_i,
  input  logic             cmp_i,
  output logic [ERR_W-1:0] err_o
);
  localparam logic [ERR_W-1:0] ERR_MAX = {ERR_W{1'b1}};

  logic [ERR_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = (ref_lat_i ^ vco_lat_i) && (cnt_q != ERR_MAX);

  always_comb begin
    cnt_d = cnt_q;
    if (cmp_i)       cnt_d = '0;
    else if (cnt_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign err_o = cnt_q;

  AST_ERR_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_i |=> (cnt_q == '0)); // R4
endmodule

// File: rtl/lock_judge.sv
module lock_judge #(
  parameter int unsigned ERR_W    = 8,
  parameter int unsigned LOCK_RUN = pfdl_pkg::LOCK_RUN_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmp_i,
  input  logic [ERR_W-1:0] err_i,
  input  logic [ERR_W-1:0] thr_unlock_i,
  input  logic [ERR_W-1:0] thr_lock_i,
  output logic             lock_o
);
  localparam int unsigned RUN_W = $clog2(LOCK_RUN + 1);
  localparam logic [RUN_W-1:0] RUN_TOP  = RUN_W'(LOCK_RUN);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(LOCK_RUN - 1);

  logic [RUN_W-1:0] good_q, good_d;
  logic             lock_q, lock_d;
  logic             too_wide, in_band;

  assign too_wide = (err_i >= thr_unlock_i);
  assign in_band  = (err_i <= thr_lock_i);

  always_comb begin
    good_d = good_q;
    lock_d = lock_q;
    if (too_wide) begin
      good_d = '0;
      lock_d = 1'b0;
    end else if (cmp_i) begin
      if (in_band) begin
        if (good_q != RUN_TOP) good_d = good_q + 1'b1;
        if (good_q >= RUN_LAST) lock_d = 1'b1;
      end else begin
        good_d = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      good_q <= '0;
      lock_q <= 1'b0;
    end else begin
      good_q <= good_d;
      lock_q <= lock_d;
    end
  end

  assign lock_o = lock_q;

  AST_UNLOCK_FAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_i >= thr_unlock_i) |=> !lock_q); // R5
  AST_LOCK_AFTER_CMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_q) |-> $past(cmp_i)); // R6
endmodule

// File: rtl/pfd_lock_top.sv
module pfd_lock_top #(
  parameter int unsigned ERR_W    = 8,
  parameter int unsigned LOCK_RUN = pfdl_pkg::LOCK_RUN_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_tick_i,
  input  logic             vco_tick_i,
  input  logic             polarity_i,
  input  logic             pump_en_i,
  input  logic             cur_hi_i,
  input  logic             out_sel_i,
  input  logic [ERR_W-1:0] thr_unlock_i,
  input  logic [ERR_W-1:0] thr_lock_i,
  output logic             pump_up_o,
  output logic             pump_dn_o,
  output logic             pump_oe_o,
  output logic             cur_hi_o,
  output logic             lock_o,
  output logic             shared_o
);
  import pfdl_pkg::*;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic             ref_lat, vco_lat, cmp;
  logic [ERR_W-1:0] err;
  logic             lock;
  pump_req_t        req;

  pfd_core u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_int_n),
    .ref_tick_i (ref_tick_i),
    .vco_tick_i (vco_tick_i),
    .ref_lat_o  (ref_lat),
    .vco_lat_o  (vco_lat),
    .cmp_o      (cmp)
  );

  phase_meter #(.ERR_W(ERR_W)) u_meter (
    .clk_i     (clk_i),
    .rst_ni    (rst_int_n),
    .ref_lat_i (ref_lat),
    .vco_lat_i (vco_lat),
    .cmp_i     (cmp),
    .err_o     (err)
  );

  lock_judge #(.ERR_W(ERR_W), .LOCK_RUN(LOCK_RUN)) u_judge (
    .clk_i        (clk_i),
    .rst_ni       (rst_int_n),
    .cmp_i        (cmp),
    .err_i        (err),
    .thr_unlock_i (thr_unlock_i),
    .thr_lock_i   (thr_lock_i),
    .lock_o       (lock)
  );

  // Polarity selects which latched side drives the up request.
  always_comb begin
    if (polarity_i) begin
      req.up = ref_lat;
      req.dn = vco_lat;
    end else begin
      req.up = vco_lat;
      req.dn = ref_lat;
    end
  end

  assign pump_up_o = req.up & pump_en_i;
  assign pump_dn_o = req.dn & pump_en_i;
  assign pump_oe_o = pump_en_i;
  assign cur_hi_o  = cur_hi_i;
  assign lock_o    = lock;
  assign shared_o  = out_sel_i ? vco_tick_i : lock;

  AST_POL_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (pump_en_i && polarity_i && pump_up_o) |-> ref_lat); // R3
endmodule

// File: tb/pfd_lock_top_bench.sv
`timescale 1ns/100ps
module pfd_lock_top_bench;
  localparam int ERR_W = 8;
  localparam int PER   = 16;
  localparam int TU    = 3;
  localparam int TL    = 1;

  logic clk = 1'b0;
  logic rst_n;
  logic ref_tick, vco_tick, pol, pen, cur, osel;
  logic [ERR_W-1:0] thr_u, thr_l;
  logic up, dn, oe, cur_o, lock, shr;

  always #2.5 clk = ~clk;

  pfd_lock_top #(.ERR_W(ERR_W)) u_pfd_lock_top (
    .clk_i(clk), .rst_ni(rst_n), .ref_tick_i(ref_tick), .vco_tick_i(vco_tick),
    .polarity_i(pol), .pump_en_i(pen), .cur_hi_i(cur), .out_sel_i(osel),
    .thr_unlock_i(thr_u), .thr_lock_i(thr_l),
    .pump_up_o(up), .pump_dn_o(dn), .pump_oe_o(oe), .cur_hi_o(cur_o),
    .lock_o(lock), .shared_o(shr));

  typedef struct {
    int up_w;
    int dn_w;
    logic lk;
    logic oe_x;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int n_chk = 0;
  int n_bad = 0;
  int m_good = 0;
  logic m_lock = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Driver: one comparison period with VCO tick offset d from the reference tick.
  task automatic run_period(input int d, input logic fc, input logic zc, input string tag);
    exp_t e;
    int ri, vi, ad, rw, vw;
    ad = (d < 0) ? -d : d;
    ri = (d < 0) ? -d : 0;
    vi = (d < 0) ? 0 : d;
    rw = (d >= 0) ? d + 1 : 1;   // R2 widths
    vw = (d < 0) ? ad + 1 : 1;
    if (ad >= TU) begin          // R5
      m_good = 0;
      m_lock = 1'b0;
    end else if (ad <= TL) begin // R6
      m_good = m_good + 1;
      if (m_good >= 3) m_lock = 1'b1;
    end else begin
      m_good = 0;
    end
    e.up_w = !zc ? 0 : (fc ? rw : vw); // R3, R7
    e.dn_w = !zc ? 0 : (fc ? vw : rw);
    e.lk   = m_lock;
    e.oe_x = zc;
    e.tag  = tag;
    @(negedge clk);
    pol = fc;
    pen = zc;
    exp_q.push_back(e);
    for (int j = 0; j < PER; j++) begin
      ref_tick = (j == ri);
      vco_tick = (j == vi);
      @(negedge clk);
    end
    ref_tick = 1'b0;
    vco_tick = 1'b0;
  endtask

  // Monitor: counts pulse widths over each period and compares to the queue head.
  initial begin
    forever begin
      exp_t e;
      int uc, dc;
      logic oe_all;
      wait (exp_q.size() > 0);
      e = exp_q.pop_front();
      uc = 0;
      dc = 0;
      oe_all = 1'b1;
      for (int j = 0; j < PER; j++) begin
        @(negedge clk);
        #1;
        uc += int'(up);
        dc += int'(dn);
        oe_all &= (oe == e.oe_x);
      end
      check(uc == e.up_w, {e.tag, " up width"}, uc, e.up_w);
      check(dc == e.dn_w, {e.tag, " dn width"}, dc, e.dn_w);
      check(lock == e.lk, {e.tag, " lock"}, int'(lock), int'(e.lk));
      check(oe_all, {e.tag, " R7 oe"}, int'(oe), int'(e.oe_x));
    end
  end

  initial begin
    #(200000 * 5);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    ref_tick = 1'b0;
    vco_tick = 1'b0;
    pol = 1'b1;
    pen = 1'b1;
    cur = 1'b0;
    osel = 1'b0;
    thr_u = ERR_W'(TU);
    thr_l = ERR_W'(TL);
    repeat (4) @(negedge clk);
    #1;
    check(lock == 1'b0 && up == 1'b0 && dn == 1'b0, "R1 in reset", int'({lock, up, dn}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check(lock == 1'b0 && up == 1'b0 && dn == 1'b0, "R1 after release", int'({lock, up, dn}), 0);

    // R2 R4 R6: coincident ticks lock on the third comparison
    run_period(0, 1'b1, 1'b1, "R2 R6 d=0 #1");
    run_period(0, 1'b1, 1'b1, "R6 d=0 #2");
    run_period(0, 1'b1, 1'b1, "R6 d=0 #3");
    run_period(1, 1'b1, 1'b1, "R4 d=1 locked");
    // R5: wide error unlocks
    run_period(4, 1'b1, 1'b1, "R5 d=4");
    // R6: mid-band restarts the run
    run_period(1, 1'b1, 1'b1, "R6 d=1 #1");
    run_period(-1, 1'b1, 1'b1, "R6 d=-1 #2");
    run_period(2, 1'b1, 1'b1, "R6 mid d=2");
    run_period(-1, 1'b1, 1'b1, "R6 d=-1 #1");
    run_period(0, 1'b1, 1'b1, "R6 d=0 #2b");
    run_period(-1, 1'b1, 1'b1, "R6 d=-1 #3");
    // R6 hysteresis: mid-band keeps lock
    run_period(2, 1'b1, 1'b1, "R6 mid keeps lock");
    // R5: VCO leading by threshold unlocks
    run_period(-3, 1'b1, 1'b1, "R5 d=-3");
    // R3: polarity swap
    run_period(2, 1'b0, 1'b1, "R3 fc=0 d=2");
    run_period(-2, 1'b0, 1'b1, "R3 fc=0 d=-2");
    // R7: pump disabled, lock logic continues
    run_period(0, 1'b1, 1'b0, "R7 off #1");
    run_period(0, 1'b1, 1'b0, "R7 off #2");
    run_period(0, 1'b1, 1'b0, "R7 off #3");
    wait (exp_q.size() == 0);
    repeat (PER + 2) @(negedge clk);

    // R8: shared pin routing
    pen = 1'b1;
    osel = 1'b0;
    #1;
    check(shr == lock, "R8 shows lock", int'(shr), int'(lock));
    osel = 1'b1;
    vco_tick = 1'b1;
    #1;
    check(shr == 1'b1, "R8 shows vco tick high", int'(shr), 1);
    @(negedge clk);
    vco_tick = 1'b0;
    #1;
    check(shr == 1'b0, "R8 shows vco tick low", int'(shr), 0);
    // R9: current select passthrough
    cur = 1'b1;
    #1;
    check(cur_o == 1'b1, "R9 cur high", int'(cur_o), 1);
    cur = 1'b0;
    #1;
    check(cur_o == 1'b0, "R9 cur low", int'(cur_o), 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule